// File: doc/BRIEF.md
# Two-Level 1:16 Serial Deserializer

This block turns a one-bit serial stream, sampled on every rising edge of a fast bit clock, into 16-bit parallel words. Each incoming bit first passes through a capture flop. A 4-bit first-level shift register then gathers the bits at the full bit rate. Every fourth bit, a divide-by-4 counter lets the completed nibble move into four second-level 4-bit shift lanes. A second divide-by-4 counter, advanced once per nibble, marks the end of each 16-bit word. At that point the assembled word is copied into an output register and held for the whole word period.

All logic runs on the single bit clock; the two dividers act as clock enables. The top bit of the second divider is the parallel word clock. It is high for 8 bit periods and low for 8. It is driven out as a complementary pair with inverted polarity, so the positive pin falls exactly when a new word appears. Word boundaries come from reset alone: the first bit captured after reset is released becomes the most significant bit of the first word. No pattern search or realignment is done.

Top module: `deser16_tree`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_bit`, the block clears its state: after that edge `word_out` is 0, `word_valid` is 0, `pclk_p` is 0 and `pclk_n` is 1.
- R2: The serial bit sampled at the first rising edge with `rst` low is placed on `word_out[15]` of the first word.
- R3: Word w (counting from 0 after reset) carries stream bit 16w+i on `word_out[15-i]` for i = 0..15. Consecutive words are contiguous, with no bits dropped or repeated.
- R4: The first word appears, with `word_valid` high, after rising edge 17 counted from reset release. Later words follow every 16 rising edges.
- R5: `word_valid` is high for exactly one bit-clock cycle per word and low at all other times.
- R6: `word_out` changes only on the edge that raises `word_valid`, and holds its value in between.
- R7: `pclk_p` is low for bit-index phases 0..7 and high for phases 8..15. After rising edge e (e ≥ 1) since reset release, the phase is (e-1) mod 16, giving a 50% duty cycle.
- R8: `pclk_p` falls on the same edge that loads a new word, and `pclk_n` is always the complement of `pclk_p`.
- R9: Asserting `rst` in the middle of a word discards the partial word. The first bit captured after the new release becomes bit 15 of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock; all state updates on its rising edge |
| rst | input | 1 | Active-high synchronous reset; sets the word boundary |
| serial_in | input | 1 | Serial data bit |
| word_out | output | 16 | Registered parallel word; first received bit at the MSB |
| word_valid | output | 1 | One-cycle strobe when a new word is loaded |
| pclk_p | output | 1 | Word clock, inverted-polarity positive pin; falls when data changes |
| pclk_n | output | 1 | Complement of `pclk_p` |

## Verification
The bench builds the block with its default segment size of 4. This yields the 16-bit word and the two divide-by-4 levels, so every nibble hand-off and word transfer is reachable within a few hundred cycles. A behavioural queue model predicts the word, the strobe and both clock pins on every cycle. It does this for a pseudo-random stream, a long run of zeros, an alternating pattern, and a reset issued part-way through a word.

// File: rtl/deser16_tree.sv
module deser16_tree #(
  parameter int SEG = 4
) (
  input  logic                 clk_bit,
  input  logic                 rst,
  input  logic                 serial_in,
  output logic [SEG*SEG-1:0]   word_out,
  output logic                 word_valid,
  output logic                 pclk_p,
  output logic                 pclk_n
);
  localparam int W  = SEG * SEG;
  localparam int CW = $clog2(SEG);
  localparam logic [CW-1:0] LAST = CW'(SEG - 1);
  localparam logic [CW-1:0] HALF = CW'(SEG / 2);

  logic          din_q;
  logic          run;
  logic [CW-1:0] cnt1;
  logic [CW-1:0] cnt2;
  logic [SEG-1:0] s1;
  logic [SEG-1:0] nib;
  logic [W-1:0]  word_next;

  wire nib_done  = run && (cnt1 == LAST);
  wire word_done = nib_done && (cnt2 == LAST);

  assign nib = {s1[SEG-2:0], din_q};

  // capture flop, first-level shifter and both dividers
  always_ff @(posedge clk_bit) begin
    if (rst) begin
      din_q <= 1'b0;
      run   <= 1'b0;
      s1    <= '0;
      cnt1  <= '0;
      cnt2  <= '0;
    end else begin
      din_q <= serial_in;
      run   <= 1'b1;
      if (run) begin
        s1   <= nib;
        cnt1 <= (cnt1 == LAST) ? '0 : cnt1 + 1'b1;
        if (nib_done)
          cnt2 <= (cnt2 == LAST) ? '0 : cnt2 + 1'b1;
      end
    end
  end

  // second-level lanes: lane j collects bit j of every nibble
  for (genvar j = 0; j < SEG; j++) begin : g_lane
    logic [SEG-1:0] lane;
    always_ff @(posedge clk_bit) begin
      if (rst)
        lane <= '0;
      else if (nib_done)
        lane <= {lane[SEG-2:0], nib[j]};
    end
    for (genvar m = 0; m < SEG; m++) begin : g_bit
      if (m == 0) begin : g_new
        assign word_next[SEG*m+j] = nib[j];
      end else begin : g_old
        assign word_next[SEG*m+j] = lane[m-1];
      end
    end
  end

  always_ff @(posedge clk_bit) begin
    if (rst) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= word_done;
      if (word_done)
        word_out <= word_next;
    end
  end

  assign pclk_p = cnt2[CW-1];
  assign pclk_n = ~pclk_p;

  p_word_hold_r6: assert property (@(posedge clk_bit) disable iff (rst)
    (word_out != $past(word_out)) |-> word_valid);

  p_valid_pulse_r5: assert property (@(posedge clk_bit) disable iff (rst)
    word_valid |=> !word_valid);

  p_fall_loads_r8: assert property (@(posedge clk_bit) disable iff (rst)
    $fell(pclk_p) |-> word_valid);

  p_load_falls_r8: assert property (@(posedge clk_bit) disable iff (rst)
    word_valid |-> $fell(pclk_p));

  p_clk_phase_r7: assert property (@(posedge clk_bit) disable iff (rst)
    (pclk_p != $past(pclk_p)) |-> (cnt1 == '0 && (cnt2 == '0 || cnt2 == HALF)));

endmodule

// File: tb/deser16_tree_tb.sv
module deser16_tree_tb_top;
  logic        clk_bit = 1'b0;
  logic        rst = 1'b1;
  logic        serial_in = 1'b0;
  logic [15:0] word_out;
  logic        word_valid;
  logic        pclk_p;
  logic        pclk_n;

  int checks = 0;
  int failures = 0;
  int e = 0;
  int resets_seen = 0;
  bit q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk_bit = ~clk_bit;

  deser16_tree dut_i (
    .clk_bit(clk_bit), .rst(rst), .serial_in(serial_in),
    .word_out(word_out), .word_valid(word_valid),
    .pclk_p(pclk_p), .pclk_n(pclk_n)
  );

  always @(posedge clk_bit) begin
    if (rst) begin
      e = 0;
      q.delete();
    end else begin
      q.push_back(serial_in);
      e = e + 1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at e=%0d", req, act, exp, e);
    end
  endtask

  task automatic compare();
    logic [15:0] ew;
    logic        ev;
    logic        ep;
    int          w;
    if (rst) begin
      chk("R1 word", word_out, 16'h0);
      chk("R1 valid", {15'b0, word_valid}, 16'h0);
      chk("R1 pclk_p", {15'b0, pclk_p}, 16'h0);
      chk("R1 pclk_n", {15'b0, pclk_n}, 16'h1);
      return;
    end
    ew = 16'h0;
    ev = (e >= 17) && ((e - 17) % 16 == 0);
    if (e >= 17) begin
      w = (e - 17) / 16;
      for (int i = 0; i < 16; i++) ew[15-i] = q[16*w+i];
    end
    ep = (e >= 1) && (((e - 1) % 16) >= 8);
    if (e == 17 && resets_seen > 1) chk("R9 realigned word", word_out, ew);
    else if (e == 17) chk("R2 first word", word_out, ew);
    else if (ev) chk("R3 word", word_out, ew);
    else chk("R6 held word", word_out, ew);
    chk("R4/R5 valid", {15'b0, word_valid}, {15'b0, ev});
    chk("R7 pclk_p", {15'b0, pclk_p}, {15'b0, ep});
    chk("R8 pclk_n", {15'b0, pclk_n}, {15'b0, ~ep});
  endtask

  task automatic step(input logic b);
    @(negedge clk_bit);
    compare();
    serial_in = b;
  endtask

  function automatic logic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic do_reset(input int n);
    @(negedge clk_bit);
    compare();
    rst = 1'b1;
    repeat (n) step(1'b1);
    @(negedge clk_bit);
    compare();
    rst = 1'b0;
    resets_seen++;
    serial_in = next_lfsr();
  endtask

  initial begin
    repeat (3) step(1'b0);
    do_reset(2);
    repeat (400) step(next_lfsr());
    repeat (150) step(1'b0);
    for (int i = 0; i < 100; i++) step(i[0]);
    repeat (7) step(next_lfsr());
    do_reset(3);
    repeat (300) step(next_lfsr());
    step(1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_bit);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule